// File: doc/BRIEF.md
# Wide Multiply-Add with Split Result

This block forms `A * B + C` over operands that are `W` bits wide (64 by default). The result is `2W` bits wide and is returned as two halves on separate ports. The lower half goes to `res_lo` and the upper half to `res_hi`. The full product is kept, so a caller can chain the upper half into a following operation as a carry word. This supports multi-word multiplication and big-number arithmetic.

A one-bit `mode` input selects between two variants.

- **Unsigned mode:** both multiplier operands are unsigned, and the addend is zero-extended.
- **Mixed mode:** `A` stays unsigned, while `B` and the addend `C` are read as two's-complement values and sign-extended.

The sum wraps modulo 2^(2W). No flag or status of any kind is produced.

The multiplier is iterative. It consumes `DIGIT` bits of `B` per clock and adds one partial product per step into a `2W`-bit accumulator. The accumulator is preloaded with the widened addend. In mixed mode the last digit of `B` is taken as signed, which gives the sign bit its negative weight.

A `start` pulse while idle captures the operands. `done` pulses once when the results are written. The results hold until a later operation completes.

Top module: `wmadd_top`

## Requirements
- R1: `res_lo` carries bits `[W-1:0]` and `res_hi` carries bits `[2W-1:W]` of the `2W`-bit result `A*B + C`.
- R2: With `mode`=0, `A` and `B` are unsigned and `C` is zero-extended to `2W` bits before the addition.
- R3: With `mode`=1, `A` is unsigned and `B` is two's complement. When `B[W-1]` is 1, the product equals `-(A * (-B))`.
- R4: With `mode`=1, `C` is sign-extended to `2W` bits by replicating `C[W-1]` before the addition.
- R5: The sum wraps modulo 2^(2W). For example, all-ones operands in unsigned mode give `res_hi` = all ones and `res_lo` = 0.
- R6: `done` is high for exactly one cycle. It rises `W/DIGIT` clock edges after the edge that accepted `start`.
- R7: `res_lo` and `res_hi` change only in the cycle where `done` is high, and hold otherwise.
- R8: A `start` while `busy` is 1 is ignored. The running operation finishes with its original operands and its original timing.
- R9: After reset, `busy`, `done`, `res_lo` and `res_hi` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| mode | input | 1 | 0 = unsigned, 1 = unsigned A by signed B with signed C |
| op_a | input | W | Multiplicand (unsigned) |
| op_b | input | W | Multiplier |
| op_c | input | W | Addend |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results are written |
| res_lo | output | W | Low half of the result |
| res_hi | output | W | High half of the result |

## Verification
A result is due `W/DIGIT` rising edges after the edge that accepts `start`: 4 edges for the swept 8-bit configuration and 8 edges for the 64-bit one.

The bench drives inputs on falling edges and samples on falling edges. It counts edges from acceptance until `done` appears and compares that count to the expected latency. It reads both halves only in the cycle where `done` is high.

It then checks that `done` has dropped one cycle later and that the halves have not moved three cycles later. A `start` issued mid-operation must change neither that latency nor the result.

// File: rtl/wmadd_pkg.sv
package wmadd_pkg;
  typedef enum logic {
    MODE_UU = 1'b0,
    MODE_US = 1'b1
  } madd_mode_e;
endpackage

// File: rtl/wmadd_ctrl.sv
module wmadd_ctrl #(
  parameter int STEPS = 8,
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          accept,
  output logic          step_en,
  output logic          last_step,
  output logic [CW-1:0] step_idx,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  assign accept    = start && !busy;
  assign step_en   = busy;
  assign last_step = busy && (cnt_q == CW'(STEPS - 1));
  assign step_idx  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= last_step;
      if (accept) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else if (last_step) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else if (busy) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy)); // R6
endmodule

// File: rtl/wmadd_oprnd.sv
module wmadd_oprnd
  import wmadd_pkg::*;
#(
  parameter int W     = 64,
  parameter int DIGIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             step_en,
  input  logic             busy,
  input  logic             mode,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic [W-1:0]     op_c,
  output logic [W-1:0]     a_q,
  output logic [DIGIT-1:0] digit,
  output madd_mode_e       mode_q,
  output logic [2*W-1:0]   acc_init
);
  logic [W-1:0] b_sh;

  // Widen the addend: zero fill for unsigned mode, sign fill for mixed mode.
  function automatic logic [2*W-1:0] widen_addend(input logic [W-1:0] c,
                                                  input madd_mode_e m);
    logic fill;
    fill = (m == MODE_US) && c[W-1];
    return {{W{fill}}, c};
  endfunction

  assign acc_init = widen_addend(op_c, madd_mode_e'(mode));
  assign digit    = b_sh[DIGIT-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_sh   <= '0;
      mode_q <= MODE_UU;
    end else if (accept) begin
      a_q    <= op_a;
      b_sh   <= op_b;
      mode_q <= madd_mode_e'(mode);
    end else if (step_en) begin
      b_sh <= b_sh >> DIGIT;
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(a_q)); // R8
endmodule

// File: rtl/wmadd_pp.sv
module wmadd_pp #(
  parameter int W     = 64,
  parameter int DIGIT = 8,
  localparam int SHW  = $clog2(2 * W) + 1
) (
  input  logic [W-1:0]     a,
  input  logic [DIGIT-1:0] digit,
  input  logic             neg_weight,
  input  logic [SHW-1:0]   shamt,
  output logic [2*W-1:0]   pp
);
  // Partial product, modulo 2^(2W); the digit may carry negative weight.
  function automatic logic [2*W-1:0] partial(input logic [W-1:0] av,
                                             input logic [DIGIT-1:0] dv,
                                             input logic sgn);
    logic [2*W-1:0] dext;
    dext = {{(2*W-DIGIT){sgn && dv[DIGIT-1]}}, dv};
    return {{W{1'b0}}, av} * dext;
  endfunction

  assign pp = partial(a, digit, neg_weight) << shamt;
endmodule

// File: rtl/wmadd_top.sv
module wmadd_top
  import wmadd_pkg::*;
#(
  parameter int W     = 64,
  parameter int DIGIT = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         mode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi
);
  localparam int STEPS = W / DIGIT;
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int SHW   = $clog2(2 * W) + 1;

  logic             accept, step_en, last_step;
  logic [CW-1:0]    step_idx;
  logic [W-1:0]     a_q;
  logic [DIGIT-1:0] digit;
  madd_mode_e       mode_q;
  logic [2*W-1:0]   acc_init, acc_q, pp, acc_next;
  logic [SHW-1:0]   shamt;
  logic             neg_weight;

  wmadd_ctrl #(.STEPS(STEPS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .step_en(step_en), .last_step(last_step), .step_idx(step_idx),
    .busy(busy), .done(done)
  );

  wmadd_oprnd #(.W(W), .DIGIT(DIGIT)) oprnd_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .step_en(step_en),
    .busy(busy), .mode(mode), .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .a_q(a_q), .digit(digit), .mode_q(mode_q), .acc_init(acc_init)
  );

  assign shamt      = SHW'(step_idx) * SHW'(DIGIT);
  assign neg_weight = last_step && (mode_q == MODE_US);

  wmadd_pp #(.W(W), .DIGIT(DIGIT)) pp_i (
    .a(a_q), .digit(digit), .neg_weight(neg_weight), .shamt(shamt), .pp(pp)
  );

  assign acc_next = acc_q + pp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      res_lo <= '0;
      res_hi <= '0;
    end else begin
      if (accept)       acc_q <= acc_init;
      else if (step_en) acc_q <= acc_next;
      if (last_step) begin
        res_lo <= acc_next[W-1:0];
        res_hi <= acc_next[2*W-1:W];
      end
    end
  end

  initial begin
    assert (W % DIGIT == 0 && STEPS >= 2)
      else $error("W must be a multiple of DIGIT with at least two steps"); // R6
  end

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({res_hi, res_lo})); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
endmodule

// File: tb/wmadd_top_tb_top.sv
module wmadd_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;

  // Small configuration: W=8, DIGIT=2 (4 steps).
  logic s_start = 1'b0, s_mode = 1'b0;
  logic [7:0] s_a = '0, s_b = '0, s_c = '0;
  logic s_busy, s_done;
  logic [7:0] s_lo, s_hi;

  // Full configuration: W=64, DIGIT=8 (8 steps).
  logic w_start = 1'b0, w_mode = 1'b0;
  logic [63:0] w_a = '0, w_b = '0, w_c = '0;
  logic w_busy, w_done;
  logic [63:0] w_lo, w_hi;

  wmadd_top #(.W(8), .DIGIT(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(s_start), .mode(s_mode),
    .op_a(s_a), .op_b(s_b), .op_c(s_c), .busy(s_busy), .done(s_done),
    .res_lo(s_lo), .res_hi(s_hi)
  );

  wmadd_top dut64_i (
    .clk(clk), .rst_n(rst_n), .start(w_start), .mode(w_mode),
    .op_a(w_a), .op_b(w_b), .op_c(w_c), .busy(w_busy), .done(w_done),
    .res_lo(w_lo), .res_hi(w_hi)
  );

  function automatic logic [127:0] model(input logic [63:0] a, input logic [63:0] b,
                                         input logic [63:0] c, input int w, input bit mixed);
    logic [127:0] ae, be, ce, s;
    for (int i = 0; i < 128; i++) begin
      ae[i] = (i < w) ? a[i] : 1'b0;
      be[i] = (i < w) ? b[i] : (mixed & b[w-1]);
      ce[i] = (i < w) ? c[i] : (mixed & c[w-1]);
    end
    s = ae * be + ce;
    for (int i = 0; i < 128; i++) if (i >= 2 * w) s[i] = 1'b0;
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_small(input logic [7:0] a, input logic [7:0] b,
                           input logic [7:0] c, input bit mixed);
    int lat;
    logic [127:0] exp;
    s_a = a; s_b = b; s_c = c; s_mode = mixed; s_start = 1'b1;
    @(posedge clk); @(negedge clk);
    s_start = 1'b0;
    lat = 0;
    while (!s_done && lat < 40) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    check(lat == 4, "R6 latency", 128'(lat), 128'd4);
    exp = model({56'd0, a}, {56'd0, b}, {56'd0, c}, 8, mixed);
    check({s_hi, s_lo} == exp[15:0], mixed ? "R1 R3 R4" : "R1 R2",
          {112'd0, s_hi, s_lo}, exp);
  endtask

  task automatic run_wide(input logic [63:0] a, input logic [63:0] b,
                          input logic [63:0] c, input bit mixed, input string tag,
                          input bit poke_busy);
    int lat;
    logic [127:0] exp;
    w_a = a; w_b = b; w_c = c; w_mode = mixed; w_start = 1'b1;
    @(posedge clk); @(negedge clk);
    w_start = 1'b0;
    if (poke_busy) begin
      // R8: new operands and start while busy must be ignored.
      w_a = ~a; w_b = 64'd3; w_c = 64'd7; w_mode = ~mixed; w_start = 1'b1;
      @(posedge clk); @(negedge clk);
      w_start = 1'b0;
      lat = 1;
    end else lat = 0;
    while (!w_done && lat < 60) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    check(lat == 8, poke_busy ? "R8 R6 latency" : "R6 latency", 128'(lat), 128'd8);
    exp = model(a, b, c, 64, mixed);
    check({w_hi, w_lo} == exp, tag, {w_hi, w_lo}, exp);
    @(posedge clk); @(negedge clk);
    check(!w_done, "R6 done drops", 128'(w_done), 128'd0);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check({w_hi, w_lo} == exp, "R7 hold", {w_hi, w_lo}, exp);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    logic [7:0] avals [10];
    logic [7:0] cvals [3];
    avals = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h55, 8'h7F, 8'h80, 8'hAA, 8'hFE, 8'hFF};
    cvals = '{8'h00, 8'h80, 8'hFF};
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!s_busy && !s_done && s_lo == 0 && s_hi == 0, "R9 small",
          {s_busy, s_done, s_hi, s_lo}, 128'd0);
    check(!w_busy && !w_done && w_lo == 0 && w_hi == 0, "R9 wide",
          {w_busy, w_done, w_hi, w_lo}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // 64-bit corner cases
    run_wide('1, '1, '1, 1'b0, "R5 all ones unsigned", 1'b0);
    check(w_hi == '1 && w_lo == 64'd0, "R5 wrap", {w_hi, w_lo}, {64'hFFFF_FFFF_FFFF_FFFF, 64'd0});
    run_wide('1, '1, '1, 1'b1, "R3 R4 all ones mixed", 1'b0);
    run_wide('1, 64'h8000_0000_0000_0000, 64'd5, 1'b1, "R3 B most negative", 1'b0);
    run_wide('1, 64'h8000_0000_0000_0000, 64'd5, 1'b0, "R2 B msb unsigned", 1'b0);
    run_wide(64'd12345, 64'd678, 64'hFFFF_FFFF_FFFF_FFF0, 1'b1, "R4 C negative", 1'b0);
    run_wide(64'd12345, 64'd678, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, "R2 C zero-extended", 1'b0);
    run_wide(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h8000_0000_0000_0001,
             1'b1, "R1 R3 R4 mixed pattern", 1'b1);
    run_wide(64'hDEAD_BEEF_0000_0001, 64'h0000_0001_0000_0000, 64'd0,
             1'b0, "R1 R8 unsigned pattern", 1'b1);

    // Near-exhaustive sweep on the 8-bit configuration
    for (int m = 0; m < 2; m++)
      for (int ia = 0; ia < 10; ia++)
        for (int ib = 0; ib < 256; ib++)
          for (int ic = 0; ic < 3; ic++)
            run_small(avals[ia], 8'(ib), cvals[ic], m[0]);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule